// File: doc/BRIEF.md
# GPIO Line Interrupt Cause Unit

This block turns a bank of general-purpose input lines into grouped interrupt requests. Each line passes through a two-flop synchroniser. It is then XORed with a per-line polarity bit to form the polarity-adjusted input value.

That value feeds two paths:
- a level path, which passes through live under a level mask;
- an edge path, which holds a sticky cause bit under its own mask.

The two paths are ORed per line, and the lines are ORed in groups of eight into the summary request outputs.

Software sees the registers through a simple synchronous read/write port. Read data arrives one cycle after the request. The block also holds the output-value and direction registers for the lines, and brings them out to the pad logic.

Word offsets:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | output value | read/write |
| 0x04 | direction | read/write |
| 0x08 | polarity | read/write |
| 0x0C | data-in | read-only |
| 0x10 | edge cause | read/write |
| 0x14 | edge mask | read/write |
| 0x18 | level mask | read/write |

Top module: `gpio_irq_cause`

## Requirements
- R1: With direction bit 1 (input), data-in bit n read at offset 0x0C equals the synchronised line n XOR polarity bit n, so polarity 0 passes the line and polarity 1 inverts it.
- R2: The level path of line n is data-in bit n AND level mask bit n (offset 0x18). It is not latched, and follows the line two cycles behind the pin.
- R3: A 0-to-1 change of polarity-adjusted data-in n sets edge cause bit n (offset 0x10), which stays set after the line returns. Polarity 0 catches rising line edges and polarity 1 catches falling ones; the opposite edge sets nothing.
- R4: A polarity write that flips data-in n from 0 to 1 sets edge cause bit n like a line transition.
- R5: Writing the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends set.
- R7: The request of line n is the level path OR (cause bit n AND edge mask bit n, offset 0x14). irq[g] is the OR of lines 8g to 8g+7.
- R8: For a line with direction bit 0 (output), data-in reads return the output register bit (offset 0x00). The output and direction registers appear on out_val and out_dir.
- R9: After reset every register is zero and irq is zero.
- R10: A read issued with rd_en in one cycle presents its data on rdata after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NLINES | Asynchronous GPIO input lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | NLINES | Write data |
| rdata | output | NLINES | Read data, one cycle after rd_en |
| out_val | output | NLINES | Output value register |
| out_dir | output | NLINES | Direction register, 1 = input |
| irq | output | NLINES/GROUP | Summary interrupt per group of eight lines |

## Verification
The bench builds the block at its defaults of 32 lines in groups of eight. All four summary outputs are therefore reachable, including the top line (31) and group boundaries such as line 8 and line 16. With that width, one 32-bit write can clear one cause bit while keeping another one set. One line can also be switched to output mode while its neighbours stay inputs. The register map fits the 5-bit address.

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int NLINES = 32,
  parameter int GROUP  = 8,
  parameter int AW     = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        line_in,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [NLINES-1:0]        wdata,
  output logic [NLINES-1:0]        rdata,
  output logic [NLINES-1:0]        out_val,
  output logic [NLINES-1:0]        out_dir,
  output logic [NLINES/GROUP-1:0]  irq
);
  localparam int NGRP = NLINES / GROUP;
  localparam logic [AW-1:0] A_OUT   = AW'(5'h00);
  localparam logic [AW-1:0] A_DIR   = AW'(5'h04);
  localparam logic [AW-1:0] A_POL   = AW'(5'h08);
  localparam logic [AW-1:0] A_DIN   = AW'(5'h0C);
  localparam logic [AW-1:0] A_CAUSE = AW'(5'h10);
  localparam logic [AW-1:0] A_EMASK = AW'(5'h14);
  localparam logic [AW-1:0] A_LMASK = AW'(5'h18);

  logic [NLINES-1:0] meta, sync, pol, din_d, cause, emask, lmask;
  logic [NLINES-1:0] din, rise, din_view, line_req;

  assign din      = sync ^ pol;
  assign rise     = din & ~din_d;
  assign din_view = (out_dir & din) | (~out_dir & out_val);
  assign line_req = (din & lmask) | (cause & emask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta    <= '0;
      sync    <= '0;
      din_d   <= '0;
      pol     <= '0;
      cause   <= '0;
      emask   <= '0;
      lmask   <= '0;
      out_val <= '0;
      out_dir <= '0;
    end else begin
      meta  <= line_in;
      sync  <= meta;
      din_d <= din;
      if (wr_en && addr == A_OUT)   out_val <= wdata;
      if (wr_en && addr == A_DIR)   out_dir <= wdata;
      if (wr_en && addr == A_POL)   pol     <= wdata;
      if (wr_en && addr == A_EMASK) emask   <= wdata;
      if (wr_en && addr == A_LMASK) lmask   <= wdata;
      cause <= ((wr_en && addr == A_CAUSE) ? (cause & wdata) : cause) | rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_OUT:   rdata <= out_val;
        A_DIR:   rdata <= out_dir;
        A_POL:   rdata <= pol;
        A_DIN:   rdata <= din_view;
        A_CAUSE: rdata <= cause;
        A_EMASK: rdata <= emask;
        A_LMASK: rdata <= lmask;
        default: rdata <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq[g] = |line_req[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_irq_cause_chk.sv
module gpio_irq_cause_chk #(
  parameter int NLINES = 32,
  parameter int GROUP  = 8,
  parameter int AW     = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [AW-1:0]           addr,
  input logic [NLINES-1:0]       wdata,
  input logic [NLINES-1:0]       rdata,
  input logic [NLINES-1:0]       out_dir,
  input logic [NLINES/GROUP-1:0] irq,
  input logic [NLINES-1:0]       din,
  input logic [NLINES-1:0]       din_d,
  input logic [NLINES-1:0]       cause,
  input logic [NLINES-1:0]       emask,
  input logic [NLINES-1:0]       lmask
);
  assert_quiet_after_reset_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq == '0 && cause == '0));

  assert_edge_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((din & ~din_d) != '0) |=> (($past(din) & ~$past(din_d) & ~cause) == '0));

  assert_no_spurious_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((cause & ~$past(cause) & ~($past(din) & ~$past(din_d))) == '0));

  assert_ones_keep_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(5'h10)) |=> (($past(cause) & $past(wdata) & ~cause) == '0));

  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> ((emask | lmask) != '0));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(5'h04)) |=> (rdata == $past(out_dir)));
endmodule

bind gpio_irq_cause gpio_irq_cause_chk #(.NLINES(NLINES), .GROUP(GROUP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .out_dir(out_dir), .irq(irq),
  .din(din), .din_d(din_d), .cause(cause), .emask(emask), .lmask(lmask)
);

// File: tb/gpio_irq_cause_bench.sv
module gpio_irq_cause_bench;
  localparam int N = 32;
  localparam int NV = 6;
  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_POL = 5'h08, A_DIN = 5'h0C,
                         A_CAUSE = 5'h10, A_EMASK = 5'h14, A_LMASK = 5'h18;

  typedef struct packed {
    logic [N-1:0] pins;
    logic [N-1:0] pol;
    logic [N-1:0] lvl;
    logic [3:0]   exp_irq;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 4'b0001},
    '{32'h0000_0100, 32'h0000_0000, 32'hFFFF_FFFF, 4'b0010},
    '{32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 4'b1000},
    '{32'h00FF_0000, 32'h0000_0000, 32'h0000_FFFF, 4'b0000},
    '{32'h0001_0000, 32'h0000_0000, 32'h0001_0000, 4'b0100},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0000}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [N-1:0] line_in = '0, wdata = '0, rdata, out_val, out_dir, rv;
  logic [3:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_cause u_gpio_irq_cause (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .out_val(out_val),
    .out_dir(out_dir), .irq(irq)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [N-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [N-1:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 irq", {28'b0, irq}, '0);
    rd(A_CAUSE, rv); chk("R9 cause", rv, '0);
    rd(A_EMASK, rv); chk("R9 edge mask", rv, '0);
    rd(A_LMASK, rv); chk("R9 level mask", rv, '0);
    rd(A_DIR, rv);   chk("R9 direction", rv, '0);

    wr(A_DIR, '1);
    rd(A_DIR, rv); chk("R10 direction readback", rv, '1);
    for (int i = 0; i < NV; i++) begin
      wr(A_POL, VECS[i].pol);
      wr(A_LMASK, VECS[i].lvl);
      line_in = VECS[i].pins;
      settle();
      chk("R2 R7 level irq", {28'b0, irq}, {28'b0, VECS[i].exp_irq});
      rd(A_DIN, rv); chk("R1 data-in", rv, VECS[i].pins ^ VECS[i].pol);
    end

    wr(A_POL, '0);
    line_in = '0;
    settle();
    wr(A_LMASK, 32'h0010_0000);
    line_in[20] = 1; settle();
    chk("R2 level follows high", {28'b0, irq}, 32'h4);
    line_in[20] = 0; settle();
    chk("R2 level follows low", {28'b0, irq}, 32'h0);
    wr(A_LMASK, '0);
    wr(A_CAUSE, '0);
    rd(A_CAUSE, rv); chk("R5 cleared", rv, '0);

    wr(A_EMASK, 32'h0000_1008);
    line_in[3] = 1; settle();
    rd(A_CAUSE, rv); chk("R3 rising sets", rv, 32'h8);
    chk("R7 edge irq", {28'b0, irq}, 32'h1);
    line_in[3] = 0; settle();
    rd(A_CAUSE, rv); chk("R3 sticky", rv, 32'h8);
    line_in[12] = 1; settle();
    rd(A_CAUSE, rv); chk("R3 second line", rv, 32'h1008);
    chk("R7 two groups", {28'b0, irq}, 32'h3);
    wr(A_CAUSE, ~32'h8);
    rd(A_CAUSE, rv); chk("R5 selective clear", rv, 32'h1000);
    chk("R7 after clear", {28'b0, irq}, 32'h2);
    line_in[12] = 0; settle();
    wr(A_CAUSE, '0);
    wr(A_EMASK, 32'h20);

    wr(A_POL, 32'h20);
    @(negedge clk);
    rd(A_CAUSE, rv); chk("R4 polarity write edge", rv, 32'h20);
    chk("R4 irq", {28'b0, irq}, 32'h1);
    wr(A_CAUSE, '0);
    line_in[5] = 1; settle();
    rd(A_CAUSE, rv); chk("R3 inverted rising ignored", rv, 32'h0);
    line_in[5] = 0; settle();
    rd(A_CAUSE, rv); chk("R3 falling caught", rv, 32'h20);
    wr(A_EMASK, '0);
    chk("R7 edge mask gates", {28'b0, irq}, 32'h0);

    wr(A_CAUSE, '0);
    wr(A_POL, 32'h0);
    settle();
    wr(A_POL, 32'h20);
    wr(A_CAUSE, '0);
    rd(A_CAUSE, rv); chk("R6 set beats clear", rv, 32'h20);

    wr(A_DIR, ~32'h1);
    wr(A_OUT, 32'h1);
    line_in[0] = 0; settle();
    rd(A_DIN, rv); chk("R8 output line reads output", rv[0], 1'b1);
    chk("R8 out_val port", out_val, 32'h1);
    wr(A_OUT, 32'h0);
    line_in[0] = 1; settle();
    rd(A_DIN, rv); chk("R8 output line ignores pin", rv[0], 1'b0);
    chk("R8 out_dir port", out_dir, ~32'h1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule